// File: doc/BRIEF.md
# Instruction Decode and Program Sequencing Unit

This block is the control half of a small single-cycle processor. It keeps a program counter, presents it as the instruction fetch address, and decodes the 16-bit word that comes back in the same cycle. The decoded control word goes to an external datapath. That datapath has an eight-entry register file, an ALU, a constant multiplexer, data memory and a write-back multiplexer. The control word carries the destination and source register indices, the ALU function code, the constant and load selects, the register and memory write strobes, and a constant sign-extended from the instruction.

The top three opcode bits pick one of eight instruction categories. The next four opcode bits either supply the low ALU function bits or name a branch condition. Branches test the status flags that the datapath returns in the same cycle. Jumps and taken branches add a signed 6-bit offset to the current PC; all other instructions advance the PC by one.

Top module: `seqdec_top`

## Requirements
- R1: While `rst_n` is low the PC (`imem_addr`) is 0, and it is cleared as soon as `rst_n` falls, without waiting for a clock edge. After release, the PC advances only once the internally synchronized reset has deasserted.
- R2: In every format, `dst_sel` = instr[8:6], `srca_sel` = instr[5:3] and `srcb_sel` = instr[2:0].
- R3: `const_val` is instr[2:0] sign-extended to DATA_W bits.
- R4: With category c = instr[15:13] and low opcode bits f = instr[12:9]: `alu_fn` = {0,f} when c is 000 (register ALU) or 011 (immediate ALU), {1,f} when c is 001 (register shift) or 101 (immediate shift), and 00000 for all other categories.
- R5: `const_sel` is 1 for categories 011 and 101, and for category 100 (store) when instr[9] = 1 (store constant). It is 0 for all other instructions.
- R6: `reg_we` is 1 exactly for categories 000, 001, 010, 011 and 101. `load_sel` is 1 only for category 010 (memory read).
- R7: `mem_we` is 1 exactly for category 100.
- R8: For category 111 (jump), the next PC is PC + sext({instr[8:6], instr[2:0]}), taken modulo 2^PC_W.
- R9: For category 110 (branch), the condition is taken from instr[11:9]: 000 N, 001 not N, 010 C, 011 Z, 100 not Z, 101 V, 110 not V, 111 not C. Bit 12 is ignored. A taken branch moves the PC by the same offset as R8; a branch that is not taken moves it by +1.
- R10: Every other category sets the next PC to PC + 1, taken modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_data | input | 16 | Instruction word fetched at `imem_addr` |
| flag_v | input | 1 | Signed overflow flag from the datapath |
| flag_c | input | 1 | Carry flag from the datapath |
| flag_n | input | 1 | Negative flag from the datapath |
| flag_z | input | 1 | Zero flag from the datapath |
| imem_addr | output | PC_W | Program counter / fetch address |
| dst_sel | output | 3 | Destination register index |
| srca_sel | output | 3 | A-operand register index |
| srcb_sel | output | 3 | B-operand register index |
| const_sel | output | 1 | Selects the constant in place of the B register |
| alu_fn | output | 5 | ALU function select |
| load_sel | output | 1 | Write-back takes memory data in place of the ALU result |
| reg_we | output | 1 | Register file write strobe |
| mem_we | output | 1 | Data memory write strobe |
| const_val | output | DATA_W | Sign-extended immediate |

## Verification
The bench builds the block with DATA_W = 8 and PC_W = 7. With an 8-bit constant, sign extension of the 3-bit immediate shows in the upper five bits. With a 128-word program space, both forward and backward offsets cross the wrap point within a few hundred steps. That small configuration allows a full sweep: every one of the 128 opcodes is applied under all sixteen flag combinations. In addition, all 64 jump offsets and all 512 operand-field patterns are swept. The bench predicts each control word and each next PC arithmetically from the requirements.

// File: rtl/seqdec_pkg.sv
package seqdec_pkg;

  localparam int unsigned INSTR_W = 16;
  localparam int unsigned REG_IW  = 3;
  localparam int unsigned FN_W    = 5;
  localparam int unsigned OFS_W   = 6;

  typedef enum logic [2:0] {
    CAT_ALU_R  = 3'b000,
    CAT_SHF_R  = 3'b001,
    CAT_LOAD   = 3'b010,
    CAT_ALU_I  = 3'b011,
    CAT_STORE  = 3'b100,
    CAT_SHF_I  = 3'b101,
    CAT_BRANCH = 3'b110,
    CAT_JUMP   = 3'b111
  } cat_e;

  typedef enum logic [2:0] {
    CND_NEG    = 3'b000,
    CND_NNEG   = 3'b001,
    CND_CARRY  = 3'b010,
    CND_ZERO   = 3'b011,
    CND_NZERO  = 3'b100,
    CND_OVF    = 3'b101,
    CND_NOVF   = 3'b110,
    CND_NCARRY = 3'b111
  } cond_e;

  typedef struct packed {
    logic            use_const;
    logic [FN_W-1:0] fn;
    logic            load_sel;
    logic            reg_we;
    logic            mem_we;
    logic            is_branch;
    logic            is_jump;
  } dec_t;

endpackage

// File: rtl/seqdec_fields.sv
module seqdec_fields
  import seqdec_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PC_W   = 16
) (
  input  logic [INSTR_W-1:0] instr,
  output cat_e               cat,
  output logic [3:0]         opc_lo,
  output logic [REG_IW-1:0]  dst,
  output logic [REG_IW-1:0]  srca,
  output logic [REG_IW-1:0]  srcb,
  output logic [DATA_W-1:0]  const_ext,
  output logic [PC_W-1:0]    offset_ext
);

  logic [OFS_W-1:0] ofs_raw;

  assign cat     = cat_e'(instr[15:13]);
  assign opc_lo  = instr[12:9];
  assign dst     = instr[8:6];
  assign srca    = instr[5:3];
  assign srcb    = instr[2:0];
  // split offset: high half shares the destination slot, low half the B slot
  assign ofs_raw = {instr[8:6], instr[2:0]};

  generate
    if (DATA_W > REG_IW) begin : g_const_sext
      assign const_ext = {{(DATA_W-REG_IW){instr[2]}}, instr[2:0]};
    end else begin : g_const_trunc
      assign const_ext = instr[DATA_W-1:0];
    end

    if (PC_W > OFS_W) begin : g_ofs_sext
      assign offset_ext = {{(PC_W-OFS_W){ofs_raw[OFS_W-1]}}, ofs_raw};
    end else begin : g_ofs_trunc
      // modulo arithmetic: low bits carry the full offset
      assign offset_ext = ofs_raw[PC_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/seqdec_ctrl_dec.sv
module seqdec_ctrl_dec
  import seqdec_pkg::*;
(
  input  cat_e       cat,
  input  logic [3:0] opc_lo,
  output dec_t       dec
);

  always_comb begin
    dec = '0;
    unique case (cat)
      CAT_ALU_R: begin
        dec.fn     = {1'b0, opc_lo};
        dec.reg_we = 1'b1;
      end
      CAT_SHF_R: begin
        dec.fn     = {1'b1, opc_lo};
        dec.reg_we = 1'b1;
      end
      CAT_LOAD: begin
        dec.load_sel = 1'b1;
        dec.reg_we   = 1'b1;
      end
      CAT_ALU_I: begin
        dec.fn        = {1'b0, opc_lo};
        dec.use_const = 1'b1;
        dec.reg_we    = 1'b1;
      end
      CAT_STORE: begin
        dec.mem_we    = 1'b1;
        dec.use_const = opc_lo[0];
      end
      CAT_SHF_I: begin
        dec.fn        = {1'b1, opc_lo};
        dec.use_const = 1'b1;
        dec.reg_we    = 1'b1;
      end
      CAT_BRANCH: dec.is_branch = 1'b1;
      CAT_JUMP:   dec.is_jump   = 1'b1;
      default:    dec = '0;
    endcase
  end

endmodule

// File: rtl/seqdec_cond.sv
module seqdec_cond
  import seqdec_pkg::*;
(
  input  logic [2:0] cond_code,
  input  logic       flag_v,
  input  logic       flag_c,
  input  logic       flag_n,
  input  logic       flag_z,
  output logic       taken
);

  always_comb begin
    unique case (cond_e'(cond_code))
      CND_NEG:    taken = flag_n;
      CND_NNEG:   taken = !flag_n;
      CND_CARRY:  taken = flag_c;
      CND_ZERO:   taken = flag_z;
      CND_NZERO:  taken = !flag_z;
      CND_OVF:    taken = flag_v;
      CND_NOVF:   taken = !flag_v;
      CND_NCARRY: taken = !flag_c;
      default:    taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/seqdec_pc.sv
module seqdec_pc #(
  parameter int unsigned PC_W    = 16,
  parameter int unsigned SYNC_ST = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rel_sel,
  input  logic [PC_W-1:0] offset,
  output logic [PC_W-1:0] pc,
  output logic            core_rst_n
);

  logic [SYNC_ST-1:0] sync_q;
  logic [PC_W-1:0]    pc_q;
  logic [PC_W-1:0]    pc_d;
  logic [PC_W-1:0]    step;
  logic               pc_en;

  // reset synchronizer: asserts at once, deasserts after SYNC_ST edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_ST-2:0], 1'b1};
  end

  assign core_rst_n = sync_q[SYNC_ST-1];

  always_comb begin
    step  = rel_sel ? offset : PC_W'(1);
    pc_d  = pc_q + step;
    pc_en = core_rst_n;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  pc_q <= '0;
    else if (pc_en)   pc_q <= pc_d;
  end

  assign pc = pc_q;

endmodule

// File: rtl/seqdec_top.sv
module seqdec_top
  import seqdec_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       imem_data,
  input  logic              flag_v,
  input  logic              flag_c,
  input  logic              flag_n,
  input  logic              flag_z,
  output logic [PC_W-1:0]   imem_addr,
  output logic [2:0]        dst_sel,
  output logic [2:0]        srca_sel,
  output logic [2:0]        srcb_sel,
  output logic              const_sel,
  output logic [4:0]        alu_fn,
  output logic              load_sel,
  output logic              reg_we,
  output logic              mem_we,
  output logic [DATA_W-1:0] const_val
);

  cat_e            cat;
  logic [3:0]      opc_lo;
  logic [PC_W-1:0] offset_ext;
  dec_t            dec;
  logic            cond_hit;
  logic            rel_sel;
  logic            core_rst_n;

  seqdec_fields #(.DATA_W(DATA_W), .PC_W(PC_W)) fields_i (
    .instr      (imem_data),
    .cat        (cat),
    .opc_lo     (opc_lo),
    .dst        (dst_sel),
    .srca       (srca_sel),
    .srcb       (srcb_sel),
    .const_ext  (const_val),
    .offset_ext (offset_ext)
  );

  seqdec_ctrl_dec dec_i (
    .cat    (cat),
    .opc_lo (opc_lo),
    .dec    (dec)
  );

  seqdec_cond cond_i (
    .cond_code (opc_lo[2:0]),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .taken     (cond_hit)
  );

  assign rel_sel = dec.is_jump | (dec.is_branch & cond_hit);

  seqdec_pc #(.PC_W(PC_W)) pc_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rel_sel    (rel_sel),
    .offset     (offset_ext),
    .pc         (imem_addr),
    .core_rst_n (core_rst_n)
  );

  assign const_sel = dec.use_const;
  assign alu_fn    = dec.fn;
  assign load_sel  = dec.load_sel;
  assign reg_we    = dec.reg_we;
  assign mem_we    = dec.mem_we;

endmodule

// File: rtl/seqdec_chk.sv
module seqdec_chk #(
  parameter int unsigned PC_W = 16
) (
  input logic            clk,
  input logic            core_rst_n,
  input logic [2:0]      cat_in,
  input logic [5:0]      ad_in,
  input logic [PC_W-1:0] pc,
  input logic            reg_we,
  input logic            mem_we,
  input logic            load_sel
);

  logic [PC_W-1:0] exp_ofs;
  assign exp_ofs = PC_W'($signed(ad_in));

  // R1: PC held at zero while the core reset is active
  a_r1_pc_zero_in_reset: assert property (@(posedge clk)
    !core_rst_n |-> pc == '0);

  // R7: memory writes only come from the store category
  a_r7_mw_only_store: assert property (@(posedge clk) disable iff (!core_rst_n)
    mem_we |-> cat_in == 3'b100);

  // R6: flow-control instructions never write state
  a_r6_flow_no_write: assert property (@(posedge clk) disable iff (!core_rst_n)
    cat_in[2:1] == 2'b11 |-> !reg_we && !mem_we);

  // R6: memory-read select comes with a register write
  a_r6_load_writes: assert property (@(posedge clk) disable iff (!core_rst_n)
    load_sel |-> reg_we && cat_in == 3'b010);

  // R8: jump lands at PC plus signed offset
  a_r8_jump_target: assert property (@(posedge clk) disable iff (!core_rst_n)
    cat_in == 3'b111 |=> pc == $past(pc) + $past(exp_ofs));

  // R10: non-flow instructions step by one
  a_r10_seq_step: assert property (@(posedge clk) disable iff (!core_rst_n)
    cat_in[2:1] != 2'b11 |=> pc == $past(pc) + PC_W'(1));

endmodule

bind seqdec_top seqdec_chk #(.PC_W(PC_W)) chk_i (
  .clk        (clk),
  .core_rst_n (core_rst_n),
  .cat_in     (imem_data[15:13]),
  .ad_in      ({imem_data[8:6], imem_data[2:0]}),
  .pc         (imem_addr),
  .reg_we     (reg_we),
  .mem_we     (mem_we),
  .load_sel   (load_sel)
);

// File: tb/seqdec_top_tb_top.sv
`timescale 1ns/1ps
module seqdec_top_tb_top;

  localparam int DW = 8;
  localparam int PW = 7;
  localparam int PC_MOD = 1 << PW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [15:0]   imem_data;
  logic          flag_v, flag_c, flag_n, flag_z;
  logic [PW-1:0] imem_addr;
  logic [2:0]    dst_sel, srca_sel, srcb_sel;
  logic          const_sel, load_sel, reg_we, mem_we;
  logic [4:0]    alu_fn;
  logic [DW-1:0] const_val;

  int checks = 0;
  int errors = 0;
  int exp_pc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  seqdec_top #(.DATA_W(DW), .PC_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .imem_data(imem_data),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z),
    .imem_addr(imem_addr), .dst_sel(dst_sel), .srca_sel(srca_sel),
    .srcb_sel(srcb_sel), .const_sel(const_sel), .alu_fn(alu_fn),
    .load_sel(load_sel), .reg_we(reg_we), .mem_we(mem_we),
    .const_val(const_val)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (instr %h)", req, act, exp, imem_data);
    end
  endtask

  // apply one instruction with flags {v,c,n,z}; check decode and next PC
  task automatic step(input logic [15:0] ins, input logic [3:0] fl);
    int cat, lo, ad, ofs, ex_fn, op3, ex_c;
    bit ex_mb, ex_wr, ex_md, ex_mw, tk;
    @(negedge clk);
    chk("R10 pc tracking", int'(imem_addr), exp_pc);
    imem_data = ins;
    {flag_v, flag_c, flag_n, flag_z} = fl;
    #1;
    cat = int'(ins[15:13]);
    lo  = int'(ins[12:9]);
    ex_fn = (cat == 0 || cat == 3) ? lo : (cat == 1 || cat == 5) ? 16 + lo : 0;
    ex_mb = (cat == 3 || cat == 5 || (cat == 4 && ins[9]));
    ex_wr = (cat == 0 || cat == 1 || cat == 2 || cat == 3 || cat == 5);
    ex_md = (cat == 2);
    ex_mw = (cat == 4);
    op3   = int'(ins[2:0]);
    ex_c  = (op3 >= 4) ? op3 + 248 : op3;
    chk("R2 dst", int'(dst_sel), int'(ins[8:6]));
    chk("R2 srca", int'(srca_sel), int'(ins[5:3]));
    chk("R2 srcb", int'(srcb_sel), op3);
    chk("R3 const", int'(const_val), ex_c);
    chk("R4 fn", int'(alu_fn), ex_fn);
    chk("R5 const_sel", int'(const_sel), int'(ex_mb));
    chk("R6 reg_we", int'(reg_we), int'(ex_wr));
    chk("R6 load_sel", int'(load_sel), int'(ex_md));
    chk("R7 mem_we", int'(mem_we), int'(ex_mw));
    ad  = int'({ins[8:6], ins[2:0]});
    ofs = (ad >= 32) ? ad - 64 : ad;
    case (ins[11:9])
      3'd0: tk = fl[1];
      3'd1: tk = !fl[1];
      3'd2: tk = fl[2];
      3'd3: tk = fl[0];
      3'd4: tk = !fl[0];
      3'd5: tk = fl[3];
      3'd6: tk = !fl[3];
      default: tk = !fl[2];
    endcase
    if (cat == 7 || (cat == 6 && tk)) exp_pc = ((exp_pc + ofs) % PC_MOD + PC_MOD) % PC_MOD; // R8 R9
    else exp_pc = (exp_pc + 1) % PC_MOD;                                                  // R9 R10
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    imem_data = 16'hFE00;  // jump, offset 0
    {flag_v, flag_c, flag_n, flag_z} = 4'b0000;
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", int'(imem_addr), 0);
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk("R1 pc after release with self-jump", int'(imem_addr), 0);
    end
    exp_pc = 0;

    // R4 R5 R6 R7 R9 R10: every opcode under every flag combination
    for (int op = 0; op < 128; op++) begin
      for (int f = 0; f < 16; f++) begin
        step({op[6:0], 9'((op * 37 + f * 11) % 512)}, f[3:0]);
      end
    end

    // R8: all 64 jump offsets, crossing the wrap point both ways
    for (int a = 0; a < 64; a++) begin
      step({7'b1110000, a[5:3], 3'b101, a[2:0]}, 4'b0000);
    end

    // R9: bit 12 ignored, branch-if-zero with both Z values
    step(16'b1101011_111_000_011, 4'b0001);
    step(16'b1100011_111_000_011, 4'b0000);

    // R2 R3: all operand-field patterns on an immediate ALU op
    for (int b = 0; b < 512; b++) begin
      step({7'b0110010, b[8:0]}, 4'b1111);
    end

    @(negedge clk);
    chk("R10 final pc", int'(imem_addr), exp_pc);

    // R1: reset clears the PC asynchronously, between clock edges
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 async clear", int'(imem_addr), 0);
    imem_data = 16'hFE00;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 pc after second release", int'(imem_addr), 0);
    exp_pc = 0;
    step(16'b0000010_001_010_011, 4'b0000);
    @(negedge clk);
    chk("R10 pc steps after reset", int'(imem_addr), exp_pc);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule